// File: doc/BRIEF.md
# Wavefront Branch Mask Controller

This block keeps the execution mask of a 64-item wavefront. The wavefront runs on 16 physical lanes, and each lane carries four work-items, one per consecutive issue cycle. Every lane executes the same bundle in a cycle, so the only thing that tells lanes apart is their mask bit. The block receives branch commands, each with a 64-bit condition vector. From these it builds the mask for the taken path. It then builds the mask for the opposite path from the lanes that were live at the branch and had a false condition.

When the live lanes all agree, one of the two paths has no lanes. The block flags that path with `skip` so that the issue logic can leave it out. When both paths have live lanes, the switch to the second path costs a fixed clause-switch penalty. During the penalty `busy` is high and nothing issues. A divergent branch whose paths are each 20 cycles long therefore costs 20 + 20 + 40 cycles. An eight-entry stack saves the enclosing mask so that branches can nest.

Top module: `wave_mask_ctrl`

## Requirements
- R1: After reset the mask is all ones, `issue_quarter` is 0, and `busy`, `skip` and `err` are 0.
- R2: In every cycle where `busy` is low, `issue_quarter` advances by one and wraps from 3 to 0. `issue_mask` equals mask bits [quarter*16 +: 16].
- R3: A branch-open command (`cmd_op`=1) sets the mask to the current mask AND `cmd_cond`, and saves the current mask on the stack.
- R4: A path-switch command (`cmd_op`=2) sets the mask to the saved mask AND NOT the innermost open condition. Lanes that were off before that open stay off.
- R5: A branch-close command (`cmd_op`=3) restores the saved mask and removes it from the stack. `cmd_op`=0 does nothing.
- R6: A path switch where both paths have live lanes raises `busy` for exactly PENALTY (default 40) cycles, starting in the cycle after the command. While `busy` is high, `issue_mask` is zero and `issue_quarter` holds.
- R7: A path switch where one path is empty raises no `busy`. `skip` is high whenever the whole mask is empty.
- R8: Commands that arrive while `busy` is high are ignored.
- R9: Each of the following sets a sticky `err`, and the command then has no effect on the mask: an open with 8 saved entries, or a switch or close with an empty stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 none, 1 open, 2 switch, 3 close |
| cmd_cond | input | 64 | Per-item condition for an open |
| issue_mask | output | 16 | Lane enables for the current quarter |
| issue_quarter | output | 2 | Which quarter of the wavefront issues now |
| busy | output | 1 | Clause-switch penalty in progress |
| skip | output | 1 | Current path has no live items |
| err | output | 1 | Sticky stack overflow or underflow |

## Verification
The assertions rely on PENALTY being at least 2, on QUARTERS being a power of two, and on `cmd_op` being driven only while `cmd_valid` is high. The bench drives commands at the falling edge and keeps `cmd_valid` high for one cycle only. It resets the block after each stack-error scenario, so that a set `err` cannot hide later results. It sends commands during `busy` on purpose, to show that they are ignored.

// File: rtl/wmc_pkg.sv
package wmc_pkg;
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_OPEN  = 2'd1,
        OP_SWAP  = 2'd2,
        OP_CLOSE = 2'd3
    } wmc_op_e;
endpackage

// File: rtl/wmc_mask_stack.sv
module wmc_mask_stack #(
    parameter int W     = 64,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_outer,
    input  logic [W-1:0] push_taken,
    output logic [W-1:0] top_outer,
    output logic [W-1:0] top_taken,
    output logic         empty,
    output logic         full
);
    localparam int SW = $clog2(DEPTH + 1);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  outer_mem [DEPTH];
    logic [W-1:0]  taken_mem [DEPTH];
    logic [SW-1:0] sp_d, sp_q;
    logic [SW-1:0] top_idx;

    assign empty   = (sp_q == '0);
    assign full    = (sp_q == SW'(DEPTH));
    assign top_idx = empty ? '0 : sp_q - 1'b1;
    assign top_outer = outer_mem[top_idx[AW-1:0]];
    assign top_taken = taken_mem[top_idx[AW-1:0]];

    always_comb begin
        sp_d = sp_q;
        if (push && !full)
            sp_d = sp_q + 1'b1;
        else if (pop && !empty)
            sp_d = sp_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sp_q <= '0;
        else        sp_q <= sp_d;
    end

    always_ff @(posedge clk) begin
        if (push && !full) begin
            outer_mem[sp_q[AW-1:0]] <= push_outer;
            taken_mem[sp_q[AW-1:0]] <= push_taken;
        end
    end
endmodule

// File: rtl/wmc_penalty_timer.sv
module wmc_penalty_timer #(
    parameter int PENALTY = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(PENALTY + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign busy = (cnt_q != '0);

    always_comb begin
        cnt_d = cnt_q;
        if (start)     cnt_d = CW'(PENALTY);
        else if (busy) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/wmc_lane_slice.sv
module wmc_lane_slice #(
    parameter int LANES    = 16,
    parameter int QUARTERS = 4
) (
    input  logic [LANES*QUARTERS-1:0]    mask,
    input  logic [$clog2(QUARTERS)-1:0]  sel,
    input  logic                         blank,
    output logic [LANES-1:0]             slice
);
    logic [LANES-1:0] parts [QUARTERS];

    for (genvar q = 0; q < QUARTERS; q++) begin : g_part
        assign parts[q] = mask[q*LANES +: LANES];
    end

    assign slice = blank ? '0 : parts[sel];
endmodule

// File: rtl/wave_mask_ctrl.sv
module wave_mask_ctrl #(
    parameter int LANES    = 16,
    parameter int QUARTERS = 4,
    parameter int DEPTH    = 8,
    parameter int PENALTY  = 40
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                cmd_valid,
    input  logic [1:0]                          cmd_op,
    input  logic [LANES*QUARTERS-1:0]           cmd_cond,
    output logic [LANES-1:0]                    issue_mask,
    output logic [$clog2(QUARTERS)-1:0]         issue_quarter,
    output logic                                busy,
    output logic                                skip,
    output logic                                err
);
    import wmc_pkg::*;

    localparam int W  = LANES * QUARTERS;
    localparam int QW = $clog2(QUARTERS);

    typedef struct packed {
        logic [W-1:0]  mask;
        logic [QW-1:0] quarter;
        logic          err;
    } ctrl_t;

    ctrl_t        st_d, st_q;
    logic         push, pop, start;
    logic [W-1:0] top_outer, top_taken, swap_mask;
    logic         stk_empty, stk_full;
    wmc_op_e      op;

    assign op = wmc_op_e'(cmd_op);

    wmc_mask_stack #(.W(W), .DEPTH(DEPTH)) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .pop        (pop),
        .push_outer (st_q.mask),
        .push_taken (st_q.mask & cmd_cond),
        .top_outer  (top_outer),
        .top_taken  (top_taken),
        .empty      (stk_empty),
        .full       (stk_full)
    );

    wmc_penalty_timer #(.PENALTY(PENALTY)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy)
    );

    wmc_lane_slice #(.LANES(LANES), .QUARTERS(QUARTERS)) u_slice (
        .mask  (st_q.mask),
        .sel   (st_q.quarter),
        .blank (busy),
        .slice (issue_mask)
    );

    assign swap_mask = top_outer & ~top_taken;

    always_comb begin
        st_d  = st_q;
        push  = 1'b0;
        pop   = 1'b0;
        start = 1'b0;
        if (!busy)
            st_d.quarter = QW'(st_q.quarter + 1'b1);
        if (cmd_valid && !busy) begin
            case (op)
                OP_OPEN: begin
                    if (stk_full) st_d.err = 1'b1;
                    else begin
                        push      = 1'b1;
                        st_d.mask = st_q.mask & cmd_cond;
                    end
                end
                OP_SWAP: begin
                    if (stk_empty) st_d.err = 1'b1;
                    else begin
                        st_d.mask = swap_mask;
                        start = (top_taken != '0) && (swap_mask != '0);
                    end
                end
                OP_CLOSE: begin
                    if (stk_empty) st_d.err = 1'b1;
                    else begin
                        pop       = 1'b1;
                        st_d.mask = top_outer;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mask    <= '1;
            st_q.quarter <= '0;
            st_q.err     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign issue_quarter = st_q.quarter;
    assign skip          = (st_q.mask == '0);
    assign err           = st_q.err;
endmodule

// File: rtl/wmc_checker.sv
module wmc_checker #(
    parameter int LANES    = 16,
    parameter int QUARTERS = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [LANES-1:0]             issue_mask,
    input logic [$clog2(QUARTERS)-1:0]  issue_quarter,
    input logic                         busy,
    input logic                         skip,
    input logic                         err
);
    localparam int QW = $clog2(QUARTERS);

    p_busy_blank_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> issue_mask == '0);

    p_quarter_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(issue_quarter));

    p_quarter_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> issue_quarter == QW'($past(issue_quarter) + 1'b1));

    p_skip_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        skip |-> issue_mask == '0);

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    p_busy_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy);
endmodule

bind wave_mask_ctrl wmc_checker #(.LANES(LANES), .QUARTERS(QUARTERS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .issue_mask    (issue_mask),
    .issue_quarter (issue_quarter),
    .busy          (busy),
    .skip          (skip),
    .err           (err)
);

// File: tb/tb_wave_mask_ctrl.sv
`timescale 1ns/1ps
module tb_wave_mask_ctrl;
    localparam int PEN = 40;
    localparam logic [63:0] ONES = '1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [63:0] cmd_cond = '0;
    logic [15:0] issue_mask;
    logic [1:0]  issue_quarter;
    logic        busy, skip, err;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    wave_mask_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_cond(cmd_cond), .issue_mask(issue_mask), .issue_quarter(issue_quarter),
        .busy(busy), .skip(skip), .err(err)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; cmd_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send(input logic [1:0] op, input logic [63:0] c);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_cond = c;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'd0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic grab(output logic [63:0] m);
        m = '0;
        repeat (4) begin
            @(negedge clk);
            m[int'(issue_quarter)*16 +: 16] = issue_mask;
        end
    endtask

    task automatic t_reset();
        do_reset();
        chk(issue_mask == 16'hFFFF && issue_quarter == 0 && !busy && !skip && !err,
            "R1 reset state", {issue_quarter, busy, skip, err, issue_mask},
            {2'd0, 3'd0, 16'hFFFF});
    endtask

    task automatic t_quarter();
        logic [1:0] prev;
        logic [63:0] m;
        prev = issue_quarter;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(issue_quarter == prev + 2'd1, "R2 quarter step", 64'(issue_quarter), 64'(prev + 2'd1));
            prev = issue_quarter;
        end
        grab(m);
        chk(m == ONES, "R2 slice of full mask", m, ONES);
    endtask

    task automatic t_divergent();
        logic [63:0] a = 64'hF0F0_1234_5678_9ABC;
        logic [63:0] m;
        int n;
        logic [1:0] q0;
        send(2'd1, a);
        grab(m);
        chk(m == a, "R3 open mask", m, a);
        send(2'd2, '0);
        chk(busy == 1'b1, "R6 busy after divergent switch", 64'(busy), 64'd1);
        chk(issue_mask == 16'h0, "R6 no issue during penalty", 64'(issue_mask), 64'd0);
        q0 = issue_quarter;
        n = 0;
        while (busy) begin
            n++;
            if (issue_quarter != q0) chk(0, "R6 quarter hold", 64'(issue_quarter), 64'(q0));
            @(negedge clk);
        end
        chk(n == PEN, "R6 penalty length", 64'(n), 64'(PEN));
        grab(m);
        chk(m == ~a, "R4 switch mask", m, ~a);
        send(2'd3, '0);
        grab(m);
        chk(m == ONES, "R5 close restores", m, ONES);
    endtask

    task automatic t_uniform();
        logic [63:0] m;
        send(2'd1, ONES);
        chk(!skip, "R7 uniform true no skip", 64'(skip), 64'd0);
        send(2'd2, '0);
        chk(!busy && skip && issue_mask == 0, "R7 uniform true switch skipped",
            {busy, skip, issue_mask}, {2'b01, 16'h0});
        send(2'd3, '0);
        send(2'd1, '0);
        chk(skip && !busy, "R7 uniform false open skipped", {busy, skip}, 2'b01);
        send(2'd2, '0);
        chk(!busy && !skip, "R7 uniform false switch free", {busy, skip}, 2'b00);
        grab(m);
        chk(m == ONES, "R7 uniform false switch mask", m, ONES);
        send(2'd0, '0);
        grab(m);
        chk(m == ONES, "R5 op none no change", m, ONES);
        send(2'd3, '0);
    endtask

    task automatic t_nested();
        logic [63:0] a = 64'h00FF_00FF_0F0F_F0F0;
        logic [63:0] b = 64'h0123_4567_89AB_CDEF;
        logic [63:0] m;
        send(2'd1, a);
        send(2'd1, b);
        grab(m);
        chk(m == (a & b), "R3 nested open", m, a & b);
        send(2'd2, '0);
        wait_idle();
        grab(m);
        chk(m == (a & ~b), "R4 nested switch keeps outer-off lanes off", m, a & ~b);
        send(2'd3, '0);
        send(2'd1, a | 64'hFFFF_0000_0000_0000);
        send(2'd2, '0);
        chk(!busy && skip, "R7 uniform over live lanes only", {busy, skip}, 2'b01);
        send(2'd3, '0);
        grab(m);
        chk(m == a, "R5 nested close", m, a);
        send(2'd2, '0);
        wait_idle();
        grab(m);
        chk(m == ~a, "R4 outer switch", m, ~a);
        send(2'd3, '0);
    endtask

    task automatic t_ignore_busy();
        logic [63:0] a = 64'hAAAA_5555_FFFF_0000;
        logic [63:0] m;
        send(2'd1, a);
        send(2'd2, '0);
        send(2'd3, '0);
        send(2'd1, '0);
        wait_idle();
        grab(m);
        chk(m == ~a, "R8 commands ignored while busy", m, ~a);
        send(2'd3, '0);
        grab(m);
        chk(m == ONES && !err, "R8 stack unchanged by ignored commands", m, ONES);
    endtask

    task automatic t_underflow();
        logic [63:0] m;
        do_reset();
        send(2'd3, '0);
        chk(err, "R9 close underflow err", 64'(err), 64'd1);
        grab(m);
        chk(m == ONES, "R9 underflow no mask change", m, ONES);
        do_reset();
        send(2'd2, '0);
        chk(err && !busy, "R9 switch underflow err", {err, busy}, 2'b10);
    endtask

    task automatic t_overflow();
        logic [63:0] m;
        do_reset();
        for (int i = 0; i < 8; i++) send(2'd1, ONES);
        chk(!err, "R9 eight opens fit", 64'(err), 64'd0);
        send(2'd1, '0);
        chk(err, "R9 overflow err", 64'(err), 64'd1);
        grab(m);
        chk(m == ONES, "R9 overflow no mask change", m, ONES);
        do_reset();
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_quarter();
                t_divergent();
                t_uniform();
                t_nested();
                t_ignore_busy();
                t_underflow();
                t_overflow();
            end
            begin
                repeat (20000) @(posedge clk);
                chk(0, "watchdog", 64'd0, 64'd1);
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule